// File: doc/BRIEF.md
# Delay-Matching Calibration Search Controller

This controller steers a temperature sensor built from two delay lines. One line is locked to a stable clock, so each of its taps gives a delay that does not move with temperature. The other line runs open loop, so its delay per tap follows process and temperature. The controller picks one tap on each line. It reads a single early/late bit from a bang-bang phase detector that compares the two delayed edges.

A calibration run fixes the reference tap at a programmed value. It then walks the open-loop tap upward from zero until the detector decision flips. The tap where the flip happens is kept as the process-corner code. A measurement run holds the open-loop tap at that stored code and walks the reference tap up from zero until the decision flips again. The reference tap found this way is the temperature code.

After every tap change the controller waits a fixed number of settling cycles before it reads the detector. Completion of each run is signalled by a one-cycle strobe that comes with its code. A sweep that reaches the last tap without a flip stops there and raises a sticky range flag.

Top module: `dly_match_ctrl`

## Requirements
- R1: A start_cal pulse while idle latches cal_ref_tap. ref_tap then holds that value for the whole calibration run, while ol_tap starts at 0 and moves up by exactly one tap per step.
- R2: Each tap is held for SETTLE_CYC clock cycles (default 4) before the detector is sampled. If the match is found at tap k, the done strobe is high in the cycle that follows the clock edge SETTLE_CYC*(k+1) edges after the edge that captured the start pulse.
- R3: The detector sample taken at tap 0 is the baseline. The first later sample whose value differs from the baseline marks the match. In calibration that tap is stored on corner_code, and cal_done is high for exactly one cycle.
- R4: A start_meas pulse while idle and calibrated starts a measurement. ol_tap equals corner_code for the whole run, and ref_tap sweeps from 0 by one. The matching reference tap appears on temp_code, with meas_valid high for exactly one cycle.
- R5: Every measurement restarts its sweep at reference tap 0. corner_code stays unchanged across any number of measurements.
- R6: A start_meas pulse received before any successful calibration is ignored: busy stays low and no meas_valid is produced.
- R7: A sweep that samples tap 127 without a match stops with that tap still applied. It sets out_of_range and returns to idle without a done strobe. out_of_range stays set until reset. A failed calibration leaves corner_code and calibrated unchanged, and a failed measurement leaves temp_code unchanged.
- R8: start_cal and start_meas pulses that arrive while a run is busy are ignored. The run in progress completes with its own result.
- R9: After reset, busy, cal_done, meas_valid, calibrated and out_of_range are 0, and corner_code, temp_code, ref_tap and ol_tap are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_cal | input | 1 | Pulse: begin calibration run |
| start_meas | input | 1 | Pulse: begin measurement run |
| cal_ref_tap | input | 7 | Reference tap to hold during calibration |
| pd_late | input | 1 | Detector decision: 1 when the reference edge arrives after the open-loop edge |
| ref_tap | output | 7 | Tap select for the stable reference line |
| ol_tap | output | 7 | Tap select for the open-loop line |
| busy | output | 1 | A sweep is in progress |
| cal_done | output | 1 | One-cycle strobe: calibration matched |
| meas_valid | output | 1 | One-cycle strobe: measurement matched |
| corner_code | output | 7 | Stored process-corner tap |
| temp_code | output | 7 | Latest temperature code |
| calibrated | output | 1 | A calibration has succeeded since reset |
| out_of_range | output | 1 | Sticky: a sweep ran off the last tap |

## Verification
The hardest conditions to reach from the ports are the sweeps that run to the last tap without a flip. They need a reference setting and a per-tap delay whose product cannot be matched within 128 taps. The bench models the two delay lines as tap count times a per-tap delay and derives the detector bit from the taps the controller drives. Choosing a long reference tap with a short open-loop delay, or a large stored corner code with a slow open-loop line, pushes a calibration sweep and then a measurement sweep past tap 127. A start pulse dropped into the middle of a busy sweep, and a measurement request issued straight after reset, cover the ignored-start cases.

// File: rtl/dmc_pkg.sv
// Shared types for the delay-matching search controller.
// Assumes: nothing beyond IEEE 1800-2017.
package dmc_pkg;
    // Which line is being swept during the current run
    typedef enum logic {
        SW_CAL  = 1'b0,   // sweep open-loop tap, reference fixed
        SW_MEAS = 1'b1    // sweep reference tap, open-loop fixed
    } sweep_mode_t;

    // Sequencer state
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/dmc_settle_timer.sv
// Settling timer: after a load, counts SETTLE_CYC-1 cycles down, then
// flags that the tap has been applied long enough to sample the detector.
// Assumes: SETTLE_CYC >= 1; the tick is only used by the caller while a sweep runs.
module dmc_settle_timer #(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic tick
);
    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Down-counter: reload on a tap change, then run down to zero and hold there
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= RELOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Detector may be sampled once the count has expired
    assign tick = (cnt == '0);
endmodule

// File: rtl/dmc_tap_sweep.sv
// Tap sweep: holds the tap being searched, records the detector baseline
// at the first sample, and reports a match (decision differs from the
// baseline) or exhaustion (last tap sampled, no match).
// Assumes: init and sample are never high together.
module dmc_tap_sweep #(
    parameter int TAP_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             sample,
    input  logic             pd_in,
    output logic [TAP_W-1:0] tap,
    output logic             hit,
    output logic             exhausted
);
    localparam logic [TAP_W-1:0] TAP_LAST = '1;

    logic first_smp;
    logic base_pd;

    // Match: any sample after the baseline that disagrees with it
    assign hit       = sample && !first_smp && (pd_in != base_pd);
    // Exhausted: the last tap was sampled and it did not match
    assign exhausted = sample && !hit && (tap == TAP_LAST);

    // Tap register, baseline capture and step-on-miss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap       <= '0;
            first_smp <= 1'b1;
            base_pd   <= 1'b0;
        end else if (init) begin
            tap       <= '0;
            first_smp <= 1'b1;
        end else if (sample) begin
            first_smp <= 1'b0;
            if (first_smp) begin
                base_pd <= pd_in;
            end
            if (!hit && !exhausted) begin
                tap <= tap + 1'b1;
            end
        end
    end

    // R1: the searched tap only stays put or moves up by one
    assert_step_by_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !init |=> (tap == $past(tap) || tap == $past(tap) + 1'b1));

    // R7: the sweep never wraps past the last tap
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && tap == TAP_LAST) |=> (tap == TAP_LAST));
endmodule

// File: rtl/dmc_seq.sv
// Sequencer: accepts start requests while idle, runs one sweep per
// request, and latches the corner code, temperature code, strobes and
// the sticky range flag.
// Assumes: hit and exhausted come from the tap sweep and are only valid with sample.
module dmc_seq #(
    parameter int TAP_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_cal,
    input  logic                 start_meas,
    input  logic [TAP_W-1:0]     nc_in,
    input  logic                 tick,
    input  logic                 hit,
    input  logic                 exhausted,
    input  logic [TAP_W-1:0]     sweep_tap,
    output logic                 sweep_init,
    output logic                 timer_load,
    output logic                 sample,
    output logic                 busy,
    output dmc_pkg::sweep_mode_t mode,
    output logic [TAP_W-1:0]     nc_hold,
    output logic [TAP_W-1:0]     mc_code,
    output logic [TAP_W-1:0]     nm_code,
    output logic                 cal_done,
    output logic                 meas_valid,
    output logic                 calibrated,
    output logic                 oor
);
    import dmc_pkg::*;

    ctl_state_t state;
    logic       go_cal;
    logic       go_meas;

    // Start decoding: only from idle; calibration wins a tie; measurement needs a corner code
    always_comb begin
        go_cal  = (state == ST_IDLE) && start_cal;
        go_meas = (state == ST_IDLE) && start_meas && !start_cal && calibrated;
    end

    assign busy       = (state == ST_SWEEP);
    assign sample     = busy && tick;
    assign sweep_init = go_cal || go_meas;
    assign timer_load = sweep_init || (sample && !hit && !exhausted);

    // State, mode and latched reference tap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mode    <= SW_CAL;
            nc_hold <= '0;
        end else if (go_cal) begin
            state   <= ST_SWEEP;
            mode    <= SW_CAL;
            nc_hold <= nc_in;
        end else if (go_meas) begin
            state   <= ST_SWEEP;
            mode    <= SW_MEAS;
        end else if (sample && (hit || exhausted)) begin
            state   <= ST_IDLE;
        end
    end

    // Result codes, strobes, calibration flag and sticky range flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_code    <= '0;
            nm_code    <= '0;
            cal_done   <= 1'b0;
            meas_valid <= 1'b0;
            calibrated <= 1'b0;
            oor        <= 1'b0;
        end else begin
            cal_done   <= 1'b0;
            meas_valid <= 1'b0;
            if (sample && hit) begin
                if (mode == SW_CAL) begin
                    mc_code    <= sweep_tap;
                    calibrated <= 1'b1;
                    cal_done   <= 1'b1;
                end else begin
                    nm_code    <= sweep_tap;
                    meas_valid <= 1'b1;
                end
            end
            if (sample && exhausted) begin
                oor <= 1'b1;
            end
        end
    end

    // R3: calibration strobe lasts one cycle
    assert_cal_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_done);

    // R4: measurement strobe lasts one cycle and never coincides with calibration
    assert_meas_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |=> !meas_valid);
    assert_strobes_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(meas_valid && cal_done));

    // R6: no measurement result without a prior calibration
    assert_meas_needs_cal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> calibrated);

    // R7: the range flag is sticky
    assert_oor_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oor |=> oor);

    // R8: a run in progress is not restarted by a new start pulse
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sample) |=> (busy && $stable(mode)));
endmodule

// File: rtl/dly_match_ctrl.sv
// Delay-matching calibration search controller (top).
// Calibration holds the reference tap and sweeps the open-loop tap;
// measurement holds the stored open-loop tap and sweeps the reference tap.
// Each sweep ends when the bang-bang detector decision flips.
// Assumes: pd_late reflects the applied taps within SETTLE_CYC cycles;
// start pulses are synchronous to clk.
module dly_match_ctrl #(
    parameter int TAP_W      = 7,
    parameter int SETTLE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_cal,
    input  logic             start_meas,
    input  logic [TAP_W-1:0] cal_ref_tap,
    input  logic             pd_late,
    output logic [TAP_W-1:0] ref_tap,
    output logic [TAP_W-1:0] ol_tap,
    output logic             busy,
    output logic             cal_done,
    output logic             meas_valid,
    output logic [TAP_W-1:0] corner_code,
    output logic [TAP_W-1:0] temp_code,
    output logic             calibrated,
    output logic             out_of_range
);
    import dmc_pkg::*;

    logic             sweep_init;
    logic             timer_load;
    logic             sample;
    logic             tick;
    logic             hit;
    logic             exhausted;
    logic [TAP_W-1:0] sweep_tap;
    logic [TAP_W-1:0] nc_hold;
    sweep_mode_t      mode;

    dmc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .tick  (tick)
    );

    dmc_tap_sweep #(.TAP_W(TAP_W)) u_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (sweep_init),
        .sample    (sample),
        .pd_in     (pd_late),
        .tap       (sweep_tap),
        .hit       (hit),
        .exhausted (exhausted)
    );

    dmc_seq #(.TAP_W(TAP_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_cal  (start_cal),
        .start_meas (start_meas),
        .nc_in      (cal_ref_tap),
        .tick       (tick),
        .hit        (hit),
        .exhausted  (exhausted),
        .sweep_tap  (sweep_tap),
        .sweep_init (sweep_init),
        .timer_load (timer_load),
        .sample     (sample),
        .busy       (busy),
        .mode       (mode),
        .nc_hold    (nc_hold),
        .mc_code    (corner_code),
        .nm_code    (temp_code),
        .cal_done   (cal_done),
        .meas_valid (meas_valid),
        .calibrated (calibrated),
        .oor        (out_of_range)
    );

    // Tap steering: the swept tap goes to whichever line the mode selects
    always_comb begin
        if (mode == SW_CAL) begin
            ref_tap = nc_hold;
            ol_tap  = sweep_tap;
        end else begin
            ref_tap = sweep_tap;
            ol_tap  = corner_code;
        end
    end

    // R1: reference tap stays fixed through a calibration run
    assert_ref_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode == SW_CAL) |=> (!busy || $stable(ref_tap)));

    // R4: open-loop tap stays on the corner code through a measurement run
    assert_ol_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode == SW_MEAS) |=> (!busy || ol_tap == corner_code));

    // R5: a measurement never alters the corner code
    assert_corner_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SW_MEAS) |=> $stable(corner_code));
endmodule

// File: tb/dly_match_ctrl_test.sv
// Bench: models both delay lines as taps times a per-tap delay and drives
// the detector bit from the taps the controller selects.
module dly_match_ctrl_test;
    localparam int S = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_cal = 1'b0;
    logic       start_meas = 1'b0;
    logic [6:0] cal_ref_tap = '0;
    logic       pd_late;
    logic [6:0] ref_tap, ol_tap, corner_code, temp_code;
    logic       busy, cal_done, meas_valid, calibrated, out_of_range;

    int dol = 10;               // open-loop delay per tap; reference is 10 per tap
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Detector model: 1 when the reference edge is later than the open-loop edge
    assign pd_late = (int'(ref_tap) * 10) > (int'(ol_tap) * dol);

    dly_match_ctrl #(.TAP_W(7), .SETTLE_CYC(S)) uut (
        .clk(clk), .rst_n(rst_n), .start_cal(start_cal), .start_meas(start_meas),
        .cal_ref_tap(cal_ref_tap), .pd_late(pd_late), .ref_tap(ref_tap), .ol_tap(ol_tap),
        .busy(busy), .cal_done(cal_done), .meas_valid(meas_valid),
        .corner_code(corner_code), .temp_code(temp_code), .calibrated(calibrated),
        .out_of_range(out_of_range)
    );

    always #4 clk = ~clk;   // 125 MHz

    // Vectors: nc, cal delay/tap, meas delay/tap, expected corner, expected temp code
    localparam int NV = 5;
    localparam int VEC [NV][5] = '{
        '{ 20, 10, 13, 20, 27},
        '{ 50,  8,  8, 63, 51},
        '{ 10, 25, 30,  4, 13},
        '{  1,  3, 11,  4,  5},
        '{100, 12,  9, 84, 76}
    };

    int  lat;
    bit  got;
    bit  other_seen;
    logic [6:0] mid_ol, mid_ref;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Pulse a start and follow the run; inj>0 pulses start_cal at that cycle count
    task automatic run_op(input bit is_cal, input int nc, input int inj);
        @(negedge clk);
        start_cal = is_cal; start_meas = !is_cal; cal_ref_tap = 7'(nc);
        got = 0; other_seen = 0;
        @(posedge clk); lat = 1;
        @(negedge clk);
        start_cal = 0; start_meas = 0;
        while (lat < 4000) begin
            if (lat == 2) begin mid_ol = ol_tap; mid_ref = ref_tap; end
            if (is_cal ? meas_valid : cal_done) other_seen = 1;
            if (is_cal ? cal_done : meas_valid) begin got = 1; break; end
            if (!busy && lat >= 2) break;
            start_cal = (inj > 0 && lat == inj);
            @(posedge clk); lat++;
            @(negedge clk);
            start_cal = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check_eq("R9", "busy", busy, 0);
        check_eq("R9", "calibrated", calibrated, 0);
        check_eq("R9", "out_of_range", out_of_range, 0);
        check_eq("R9", "corner_code", corner_code, 0);
        check_eq("R9", "temp_code", temp_code, 0);
        check_eq("R9", "taps", int'(ref_tap) + int'(ol_tap), 0);
        rst_n = 1;

        // R6: measurement request before calibration is ignored
        run_op(0, 0, 0);
        check_eq("R6", "meas_valid seen", got, 0);
        check_eq("R6", "busy", busy, 0);

        // Vector table: calibration then measurement per row
        for (int i = 0; i < NV; i++) begin
            dol = VEC[i][1];
            run_op(1, VEC[i][0], 0);
            check_eq("R3", "cal_done seen", got, 1);
            check_eq("R3", "corner_code", corner_code, VEC[i][3]);
            check_eq("R2", "cal latency", lat, S * (VEC[i][3] + 1) + 1);
            check_eq("R1", "ref_tap held at nc", ref_tap, VEC[i][0]);
            check_eq("R1", "ol_tap at match", ol_tap, VEC[i][3]);
            dol = VEC[i][2];
            run_op(0, 0, 0);
            check_eq("R4", "meas_valid seen", got, 1);
            check_eq("R4", "temp_code", temp_code, VEC[i][4]);
            check_eq("R4", "ol_tap during sweep", mid_ol, VEC[i][3]);
            check_eq("R2", "meas latency", lat, S * (VEC[i][4] + 1) + 1);
            check_eq("R7", "no range flag", out_of_range, 0);
        end

        // R5: repeated conversions restart at tap 0 and keep the corner code
        dol = 9;
        run_op(0, 0, 0);
        check_eq("R5", "repeat temp_code", temp_code, 76);
        check_eq("R5", "restart latency", lat, S * 77 + 1);
        check_eq("R5", "start ref tap", mid_ref, 0);
        dol = 12;
        run_op(0, 0, 0);
        check_eq("R5", "new temp_code", temp_code, 101);
        check_eq("R5", "corner kept", corner_code, 84);

        // R8: start_cal during a busy measurement is ignored
        dol = 12;
        run_op(0, 0, 10);
        check_eq("R8", "temp_code", temp_code, 101);
        check_eq("R8", "no cal_done", other_seen, 0);
        check_eq("R8", "corner_code", corner_code, 84);

        // R7: calibration runs off the end
        dol = 5;
        run_op(1, 127, 0);
        check_eq("R7", "no cal_done", got, 0);
        check_eq("R7", "out_of_range", out_of_range, 1);
        check_eq("R7", "stopped at last tap", ol_tap, 127);
        check_eq("R7", "busy", busy, 0);
        check_eq("R7", "corner unchanged", corner_code, 84);

        // R7: corner code still usable and flag still sticky
        dol = 9;
        run_op(0, 0, 0);
        check_eq("R7", "temp after failed cal", temp_code, 76);
        check_eq("R7", "flag sticky", out_of_range, 1);

        // R7: measurement runs off the end
        dol = 20;
        run_op(0, 0, 0);
        check_eq("R7", "no meas_valid", got, 0);
        check_eq("R7", "ref at last tap", ref_tap, 127);
        check_eq("R7", "temp unchanged", temp_code, 76);

        // R9/R6: reset clears everything; measurement ignored again
        @(negedge clk); rst_n = 0;
        @(posedge clk); @(negedge clk); rst_n = 1;
        check_eq("R9", "calibrated after reset", calibrated, 0);
        check_eq("R9", "flag after reset", out_of_range, 0);
        check_eq("R9", "corner after reset", corner_code, 0);
        run_op(0, 0, 0);
        check_eq("R6", "ignored after reset", got, 0);

        summary();
    end
endmodule